// File: doc/BRIEF.md
# Peripheral scatter-gather DMA sequencer

This block is a single-channel DMA engine that walks a list of task descriptors held in memory, driven by a peripheral request line. When software pulses `chStart`, the engine reads the channel's primary descriptor at `primBase`. That descriptor gives the end pointer of the task list, the end pointer of the alternate descriptor slot and a control word whose count field sets the length of the list in words. The engine then waits in arbitration for the peripheral.

Each accepted request handles one task. The engine first copies the task's four-word descriptor from the list into the alternate slot, one read and one write per word. It then moves that task's data words from source to destination and goes back to arbitration, so every task needs a fresh request. The last task in the list runs as a basic cycle. Before its data moves, the engine rewrites the primary control word with a zero cycle-control field to mark the primary descriptor invalid. After the last data word it raises `dmaDone` for one cycle and disables the channel.

An error response on the memory port aborts the whole list, disables the channel and sets a sticky error flag. Software clears the flag with `errClr`.

Top module: `dmaseq_top`

## Requirements
- R1: After a `chStart` pulse the engine issues exactly three reads, at `primBase`, `primBase+4` and `primBase+8`, and then makes no memory access until `perReq` is seen. While the channel is off (`chanOn` low), `memReq` stays low.
- R2: A request in arbitration raises `reqAck` in that same cycle. Then follow four read/write pairs, in word order 0 to 3: each reads list word `listBase+4*i` and writes it to `altBase+4*k`. Here `listBase` = primary word 0 minus 4×count, `altBase` = primary word 1 minus 12, `i` runs over the list words and `k` is the word within the descriptor.
- R3: The task's data phase makes `n+1` read/write pairs, where `n` is bits [13:4] of task word 2. Pair `j` reads `srcEnd-4n+4j` and writes the value read to `dstEnd-4n+4j`, where `srcEnd` and `dstEnd` are task words 0 and 1.
- R4: After a task that is not the last one, the engine makes no memory access and gives no `reqAck` until a new `perReq` arrives.
- R5: The list holds (count+1)/4 tasks, where count is bits [13:4] of primary word 2. Between copying the last task and moving its data, the engine writes `primBase+8` with the primary control word, bits [2:0] forced to 3'b000 and all other bits kept.
- R6: After the last data write, `dmaDone` is high for exactly one cycle, and `chanOn` is low in that cycle and afterwards.
- R7: A transfer with `memErr` high (and `memRdy` high) sets `dmaErr`, drops `chanOn` and stops all memory traffic. Later requests get no `reqAck`.
- R8: `dmaErr` stays high until `errClr` is high on a clock edge.
- R9: While `memReq` is high and `memRdy` is low, the engine holds `memReq`, `memAddr` and `memWe` steady and its sequence does not advance.
- R10: During reset `memReq`, `reqAck`, `chanOn`, `dmaDone` and `dmaErr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chStart | input | 1 | Pulse to enable the channel and load the primary descriptor |
| primBase | input | ADDR_W | Byte address of the primary descriptor |
| perReq | input | 1 | Peripheral request |
| reqAck | output | 1 | Request accepted this cycle |
| memReq | output | 1 | Memory access valid |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with `memRdy` |
| memRdy | input | 1 | Memory completes the access this cycle |
| memErr | input | 1 | Error response, valid with `memRdy` |
| chanOn | output | 1 | Channel enabled |
| dmaDone | output | 1 | One-cycle pulse at the end of the list |
| dmaErr | output | 1 | Sticky error flag |
| errClr | input | 1 | Clears `dmaErr` |

## Verification
The bench runs lists of one, two and three tasks with different word counts, both with an always-ready memory and with one that stalls every other cycle. It compares every logged memory access against the expected order. A design that dropped the re-arbitration between tasks would show extra traffic in the quiet window after each task. One that mis-counted the list would either skip the invalidating write or put it before the wrong task. A stall bug would show as duplicated or skipped entries in the log.

The error test fails the first source read of the second task and checks three things: that only that one access follows the copy, that a later request is ignored, and that the flag holds until cleared. A design that kept running after the error, or that cleared the flag by itself, would fail those checks.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int MODE_W  = 3;
  localparam int CNT_LSB = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_PRIM, S_ARB, S_CPY_RD, S_CPY_WR, S_INVAL, S_XR, S_XW, S_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    A_PRIM, A_LIST, A_ALT, A_PCTRL, A_TSRC, A_TDST
  } addrSel_t;

  typedef struct packed {
    logic     clrIdx;
    logic     incIdx;
    logic     ldPrim;
    logic     ldTask;
    logic     capBuf;
    logic     incList;
    logic     clrList;
    logic     wrCtrl;
    addrSel_t addrSel;
  } seqStrobe_t;

  typedef struct packed {
    logic idxAt2;
    logic idxAt3;
    logic xferLast;
    logic listLastWord;
    logic listDone;
  } seqStatus_t;
endpackage

// File: rtl/dmaseq_path.sv
module dmaseq_path
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] primBase,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output seqStatus_t        stat
);
  localparam int LIST_W = CNT_W + 1;
  localparam logic [ADDR_W-1:0] ALT_SPAN  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] CTRL_OFFS = ADDR_W'(8);

  logic [CNT_W-1:0]  idx;
  logic [LIST_W-1:0] listIdx;
  logic [ADDR_W-1:0] pSrcEnd, pDstEnd, tSrc, tDst;
  logic [DATA_W-1:0] pCtrl, bufWord;
  logic [CNT_W-1:0]  tNm1;
  logic [CNT_W-1:0]  pNm1;
  logic [ADDR_W-1:0] listBase, altBase, idxOff, tSpan;

  function automatic logic [ADDR_W-1:0] wordOff(input logic [LIST_W-1:0] n);
    return ADDR_W'(n) << 2;
  endfunction

  assign pNm1     = pCtrl[CNT_LSB +: CNT_W];
  assign listBase = pSrcEnd - wordOff({1'b0, pNm1});
  assign altBase  = pDstEnd - ALT_SPAN;
  assign idxOff   = wordOff({1'b0, idx});
  assign tSpan    = wordOff({1'b0, tNm1});

  always_comb begin
    unique case (strb.addrSel)
      A_LIST:  memAddr = listBase + wordOff(listIdx);
      A_ALT:   memAddr = altBase + idxOff;
      A_PCTRL: memAddr = primBase + CTRL_OFFS;
      A_TSRC:  memAddr = tSrc - tSpan + idxOff;
      A_TDST:  memAddr = tDst - tSpan + idxOff;
      default: memAddr = primBase + idxOff;
    endcase
  end

  assign memWdata = strb.wrCtrl ? {pCtrl[DATA_W-1:MODE_W], MODE_W'(0)} : bufWord;

  assign stat.idxAt2       = (idx == CNT_W'(2));
  assign stat.idxAt3       = (idx == CNT_W'(3));
  assign stat.xferLast     = (idx == tNm1);
  assign stat.listLastWord = (listIdx == {1'b0, pNm1});
  assign stat.listDone     = (listIdx > {1'b0, pNm1});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      listIdx <= '0;
      pSrcEnd <= '0;
      pDstEnd <= '0;
      pCtrl   <= '0;
      tSrc    <= '0;
      tDst    <= '0;
      tNm1    <= '0;
      bufWord <= '0;
    end else begin
      if (strb.clrIdx)      idx <= '0;
      else if (strb.incIdx) idx <= idx + CNT_W'(1);
      if (strb.clrList)      listIdx <= '0;
      else if (strb.incList) listIdx <= listIdx + LIST_W'(1);
      if (strb.capBuf) bufWord <= memRdata;
      if (strb.ldPrim) begin
        unique case (idx[1:0])
          2'd0:    pSrcEnd <= ADDR_W'(memRdata);
          2'd1:    pDstEnd <= ADDR_W'(memRdata);
          default: pCtrl   <= memRdata;
        endcase
      end
      if (strb.ldTask) begin
        unique case (idx[1:0])
          2'd0:    tSrc <= ADDR_W'(bufWord);
          2'd1:    tDst <= ADDR_W'(bufWord);
          2'd2:    tNm1 <= bufWord[CNT_LSB +: CNT_W];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chStart,
  input  logic       perReq,
  input  logic       memRdy,
  input  logic       memErr,
  input  logic       errClr,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       reqAck,
  output logic       dmaDone,
  output logic       chanOn,
  output logic       dmaErr
);
  seqState_t state, nextState;
  logic errFlag, accept, bad;

  assign memReq  = (state == S_PRIM) || (state == S_CPY_RD) || (state == S_CPY_WR) ||
                   (state == S_INVAL) || (state == S_XR) || (state == S_XW);
  assign memWe   = (state == S_CPY_WR) || (state == S_INVAL) || (state == S_XW);
  assign accept  = memReq && memRdy && !memErr;
  assign bad     = memReq && memRdy && memErr;
  assign dmaDone = (state == S_DONE);
  assign chanOn  = (state != S_IDLE) && (state != S_DONE);
  assign dmaErr  = errFlag;

  always_comb begin
    strb         = '0;
    strb.addrSel = A_PRIM;
    nextState    = state;
    reqAck       = 1'b0;
    unique case (state)
      S_IDLE: if (chStart) begin
        strb.clrIdx  = 1'b1;
        strb.clrList = 1'b1;
        nextState    = S_PRIM;
      end
      S_PRIM: if (accept) begin
        strb.ldPrim = 1'b1;
        if (stat.idxAt2) begin
          strb.clrIdx = 1'b1;
          nextState   = S_ARB;
        end else strb.incIdx = 1'b1;
      end
      S_ARB: if (perReq) begin
        reqAck      = 1'b1;
        strb.clrIdx = 1'b1;
        nextState   = S_CPY_RD;
      end
      S_CPY_RD: begin
        strb.addrSel = A_LIST;
        if (accept) begin
          strb.capBuf = 1'b1;
          nextState   = S_CPY_WR;
        end
      end
      S_CPY_WR: begin
        strb.addrSel = A_ALT;
        if (accept) begin
          strb.ldTask  = 1'b1;
          strb.incList = 1'b1;
          if (stat.idxAt3) begin
            strb.clrIdx = 1'b1;
            nextState   = stat.listLastWord ? S_INVAL : S_XR;
          end else begin
            strb.incIdx = 1'b1;
            nextState   = S_CPY_RD;
          end
        end
      end
      S_INVAL: begin
        strb.addrSel = A_PCTRL;
        strb.wrCtrl  = 1'b1;
        if (accept) nextState = S_XR;
      end
      S_XR: begin
        strb.addrSel = A_TSRC;
        if (accept) begin
          strb.capBuf = 1'b1;
          nextState   = S_XW;
        end
      end
      S_XW: begin
        strb.addrSel = A_TDST;
        if (accept) begin
          if (stat.xferLast) begin
            strb.clrIdx = 1'b1;
            nextState   = stat.listDone ? S_DONE : S_ARB;
          end else begin
            strb.incIdx = 1'b1;
            nextState   = S_XR;
          end
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
    if (bad) nextState = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (bad)         errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chStart,
  input  logic [ADDR_W-1:0] primBase,
  input  logic              perReq,
  output logic              reqAck,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRdy,
  input  logic              memErr,
  output logic              chanOn,
  output logic              dmaDone,
  output logic              dmaErr,
  input  logic              errClr
);
  seqStrobe_t strb;
  seqStatus_t stat;

  dmaseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chStart(chStart), .perReq(perReq),
    .memRdy(memRdy), .memErr(memErr), .errClr(errClr), .stat(stat),
    .strb(strb), .memReq(memReq), .memWe(memWe), .reqAck(reqAck),
    .dmaDone(dmaDone), .chanOn(chanOn), .dmaErr(dmaErr)
  );

  dmaseq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .primBase(primBase),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .stat(stat)
  );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanOn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdy,
  input logic              memErr,
  input logic              perReq,
  input logic              reqAck,
  input logic              dmaDone,
  input logic              dmaErr,
  input logic              errClr
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !chanOn |-> !memReq);

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (perReq && !memReq));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  assert_done_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> !chanOn);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> (!dmaDone && !chanOn));

  assert_err_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memRdy && memErr) |=> (dmaErr && !chanOn && !memReq));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaErr && !errClr) |=> dmaErr);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr) && $stable(memWe)));
endmodule

bind dmaseq_top dmaseq_chk #(.ADDR_W(ADDR_W)) u_dmaseqChk (
  .clk(clk), .rstN(rstN), .chanOn(chanOn), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memRdy(memRdy), .memErr(memErr), .perReq(perReq),
  .reqAck(reqAck), .dmaDone(dmaDone), .dmaErr(dmaErr), .errClr(errClr)
);

// File: tb/test_dmaseq_top.sv
`timescale 1ns/1ps
module test_dmaseq_top;
  // rows: task count, word counts of tasks 0..2, stalling memory
  localparam int VEC [0:3][0:4] = '{
    '{3, 2, 1, 3, 0},
    '{3, 4, 2, 1, 1},
    '{1, 3, 0, 0, 0},
    '{2, 1, 5, 0, 1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        chStart = 1'b0, perReq = 1'b0, errClr = 1'b0;
  logic [31:0] primBase = 32'h0;
  logic        reqAck, memReq, memWe, memRdy, memErr, chanOn, dmaDone, dmaErr;
  logic [31:0] memAddr, memWdata, memRdata;

  logic [31:0] mem [0:255];
  logic        pokeEn = 1'b0;
  logic [7:0]  pokeIdx = 8'h0;
  logic [31:0] pokeVal = 32'h0;
  logic        rdyTog = 1'b0, stallOn = 1'b0, errArm = 1'b0;
  logic [31:0] errAddr = 32'h0;

  logic [31:0] logA [0:1023];
  logic [31:0] logD [0:1023];
  logic        logW [0:1023];
  int          logN = 0, doneCnt = 0;

  logic [31:0] expA [0:63];
  logic [31:0] expD [0:63];
  logic        expW [0:63];
  int          expN = 0;
  int          checks = 0, fails = 0;

  assign memRdata = mem[memAddr[9:2]];
  assign memRdy   = !stallOn || rdyTog;
  assign memErr   = memReq && errArm && (memAddr == errAddr);

  dmaseq_top i_dmaseq_top (
    .clk(clk), .rstN(rstN), .chStart(chStart), .primBase(primBase),
    .perReq(perReq), .reqAck(reqAck), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memRdy(memRdy), .memErr(memErr), .chanOn(chanOn), .dmaDone(dmaDone),
    .dmaErr(dmaErr), .errClr(errClr)
  );

  always @(posedge clk) begin
    rdyTog <= ~rdyTog;
    if (pokeEn) mem[pokeIdx] <= pokeVal;
    else if (memReq && memRdy && memWe && !memErr) mem[memAddr[9:2]] <= memWdata;
    if (memReq && memRdy && logN < 1024) begin
      logA[logN] <= memAddr;
      logW[logN] <= memWe;
      logD[logN] <= memWe ? memWdata : memRdata;
      logN <= logN + 1;
    end
    if (dmaDone) doneCnt <= doneCnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    pokeEn = 1'b1; pokeIdx = 8'(idx); pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic push(input logic we, input int addr, input logic [31:0] d);
    expW[expN] = we; expA[expN] = 32'(addr); expD[expN] = d; expN++;
  endtask

  task automatic cmpRange(input int base, input int lo, input int hi,
                          input string req, input string what);
    bit ok = 1'b1;
    logic [31:0] act = 0, exp = 0;
    for (int i = lo; i < hi; i++) begin
      if (ok && (logA[base+i] !== expA[i] || logD[base+i] !== expD[i] ||
                 logW[base+i] !== expW[i])) begin
        ok = 1'b0; act = logA[base+i] ^ logD[base+i]; exp = expA[i] ^ expD[i];
      end
    end
    check(ok, req, what, act, exp);
  endtask

  function automatic logic [31:0] listWord(input int t, input int k, input int len, input bit last);
    case (k)
      0: return 32'((64 + 8*t + len - 1) * 4);
      1: return 32'((128 + 8*t + len - 1) * 4);
      2: return 32'(((len - 1) << 4) | (last ? 1 : 7));
      default: return 32'hC0DE_0000 + 32'(t);
    endcase
  endfunction

  function automatic logic [31:0] dataWord(input int row, input int t, input int j);
    return 32'h1000_0000 + 32'(row << 8) + 32'(t << 4) + 32'(j);
  endfunction

  function automatic logic [31:0] primCtrl(input int nT);
    return 32'hA500_0000 | 32'((4*nT - 1) << 4) | 32'd6;
  endfunction

  task automatic setupList(input int row, input int nT, input int l0, input int l1, input int l2);
    int lens [0:2];
    lens = '{l0, l1, l2};
    poke(0, 32'((16 + 4*nT - 1) * 4));
    poke(1, 32'd28);
    poke(2, primCtrl(nT));
    for (int k = 4; k < 8; k++) poke(k, 32'h0);
    for (int t = 0; t < nT; t++) begin
      for (int k = 0; k < 4; k++) poke(16 + 4*t + k, listWord(t, k, lens[t], t == nT-1));
      for (int j = 0; j < 8; j++) begin
        poke(64 + 8*t + j, dataWord(row, t, j));
        poke(128 + 8*t + j, 32'h0);
      end
    end
  endtask

  task automatic startChan(input int nT);
    int base = logN;
    chStart = 1'b1;
    @(negedge clk);
    chStart = 1'b0;
    repeat (30) @(negedge clk);
    expN = 0;
    push(0, 0, 32'((16 + 4*nT - 1) * 4));
    push(0, 4, 32'd28);
    push(0, 8, primCtrl(nT));
    check(logN - base == 3, "R1", "primary read count", 32'(logN - base), 32'd3);
    cmpRange(base, 0, 3, "R1", "primary read order");
  endtask

  task automatic runRow(input int row);
    int nT = VEC[row][0];
    int lens [0:2];
    int base, dBase;
    lens = '{VEC[row][1], VEC[row][2], VEC[row][3]};
    stallOn = VEC[row][4][0];
    setupList(row, nT, lens[0], lens[1], lens[2]);
    dBase = doneCnt;
    startChan(nT);
    for (int t = 0; t < nT; t++) begin
      bit last = (t == nT - 1);
      base = logN;
      perReq = 1'b1;
      #1;
      check(reqAck === 1'b1, "R2", "request accepted", 32'(reqAck), 32'd1);
      @(negedge clk);
      perReq = 1'b0;
      repeat (80) @(negedge clk);
      expN = 0;
      for (int k = 0; k < 4; k++) begin
        push(0, (16 + 4*t + k) * 4, listWord(t, k, lens[t], last));
        push(1, (4 + k) * 4, listWord(t, k, lens[t], last));
      end
      if (last) push(1, 8, primCtrl(nT) & ~32'h7);
      for (int j = 0; j < lens[t]; j++) begin
        push(0, (64 + 8*t + j) * 4, dataWord(row, t, j));
        push(1, (128 + 8*t + j) * 4, dataWord(row, t, j));
      end
      // R4: nothing beyond this task's own traffic while no request is pending
      check(logN - base == expN, "R4", "accesses per task", 32'(logN - base), 32'(expN));
      cmpRange(base, 0, 8, "R2", "descriptor copy");
      if (last) cmpRange(base, 8, 9, "R5", "primary invalidation write");
      cmpRange(base, last ? 9 : 8, expN, "R3", "data transfer order");
    end
    check(mem[2] === (primCtrl(nT) & ~32'h7), "R5", "primary ctrl in memory", mem[2], primCtrl(nT) & ~32'h7);
    check(doneCnt - dBase == 1, "R6", "done cycles", 32'(doneCnt - dBase), 32'd1);
    check(chanOn === 1'b0, "R6", "channel off after done", 32'(chanOn), 32'd0);
    stallOn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(memReq === 1'b0 && reqAck === 1'b0, "R10", "mem/ack in reset", {memReq, reqAck}, 0);
    check(chanOn === 1'b0 && dmaDone === 1'b0 && dmaErr === 1'b0, "R10", "flags in reset",
          {chanOn, dmaDone, dmaErr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) runRow(r);

    // R7 / R8: error on the first source read of the second task
    setupList(7, 3, 2, 2, 2);
    errAddr = 32'((64 + 8) * 4);
    errArm  = 1'b1;
    startChan(3);
    perReq = 1'b1; @(negedge clk); perReq = 1'b0;
    repeat (40) @(negedge clk);
    base = logN;
    perReq = 1'b1; @(negedge clk); perReq = 1'b0;
    repeat (40) @(negedge clk);
    check(logN - base == 9, "R7", "accesses up to the error", 32'(logN - base), 32'd9);
    check(dmaErr === 1'b1, "R7", "error flag set", 32'(dmaErr), 32'd1);
    check(chanOn === 1'b0, "R7", "channel disabled", 32'(chanOn), 32'd0);
    base = logN;
    perReq = 1'b1;
    #1;
    check(reqAck === 1'b0, "R7", "request ignored after error", 32'(reqAck), 32'd0);
    @(negedge clk); perReq = 1'b0;
    repeat (20) @(negedge clk);
    check(logN == base, "R7", "no traffic after error", 32'(logN - base), 32'd0);
    check(mem[2] === primCtrl(3), "R7", "primary left valid", mem[2], primCtrl(3));
    check(dmaErr === 1'b1, "R8", "flag held without clear", 32'(dmaErr), 32'd1);
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    check(dmaErr === 1'b0, "R8", "flag cleared", 32'(dmaErr), 32'd0);
    errArm = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule